// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides whether a CAN frame that has just been received in full gets written into the receive buffer. The receive path presents the frame identifier, its IDE flag (0 = standard 11-bit, 1 = extended 29-bit) and a one-cycle frame-valid strobe. The block compares the frame against a parameterised set of acceptance entries, from none to two. It then issues a one-cycle store strobe towards the receive FIFO when the frame is accepted and the FIFO has room. Filtering starts only after the frame has been acknowledged on the bus, so a rejected frame is still acknowledged and then dropped. The ACK logic never waits on this block.

Each entry holds an identifier pattern, a compare mask, an IDE pattern with its own compare bit, and an enable bit. Software programs the entries through a plain write port. When no entries are configured, every valid frame is stored.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset, store_o is low and every configured entry is disabled. With one or more entries configured, no frame is stored until an entry is enabled.
- R2: An entry matches when every identifier bit whose mask bit is 1 equals the entry's pattern bit. Mask bits that are 0 are don't-care. A frame is accepted when any entry matches.
- R3: When bit 29 of an entry's mask word is 1, the frame's IDE flag must equal bit 29 of the entry's pattern word. When that mask bit is 0, IDE is don't-care.
- R4: A standard identifier occupies frm_id[28:18]. For a frame with frm_ide = 0, frm_id[17:0] and mask bits 17:0 have no effect on the result.
- R5: An entry whose enable bit is 0 never matches. With all configured entries disabled, nothing is stored.
- R6: store_o is a single-cycle pulse, raised in the cycle directly after a frm_valid cycle and at no other time.
- R7: If fifo_full is high in the frm_valid cycle, no store pulse follows, whatever the match result.
- R8: With NUM_FILT = 0, every frame strobed while the FIFO is not full is stored.
- R9: A write with cfg_we high updates the entry selected by cfg_addr[1]. cfg_addr[0] = 0 writes the pattern word ({IDE, ID[28:0]} in bits 29:0) and cfg_addr[0] = 1 writes the mask word (same layout). Bit 30 of either word sets the entry's enable. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | [1] entry index, [0] 0 = pattern word, 1 = mask word |
| cfg_wdata | input | 31 | [30] enable, [29] IDE, [28:0] identifier bits |
| frm_valid | input | 1 | One-cycle strobe: frame received and acknowledged |
| frm_ide | input | 1 | Frame format, 1 = extended |
| frm_id | input | 29 | Frame identifier, standard IDs in [28:18] |
| fifo_full | input | 1 | Receive FIFO has no free slot |
| store_o | output | 1 | Write strobe to the receive FIFO |

## Verification
The hardest cases are those where the identifier bits agree but the result must still differ. One is an extended frame whose upper bits equal a standard pattern, which only the IDE compare rejects. The other is a standard frame carrying non-zero low bits under a full mask, which must still pass. The stimulus programs one entry for each format and then reuses the same identifier bits with the IDE flag flipped. It also fills the low 18 bits with varied values. A second instance with no entries runs alongside on the same frames to show unconditional acceptance, including while the FIFO is full.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int EXT_LO = ID_W - STD_W;   // low bits only meaningful for extended
  localparam int WORD_W = ID_W + 2;       // enable, ide, id

  typedef struct packed {
    logic            ide;
    logic [ID_W-1:0] id;
  } filt_word_t;

  // Mask applied to the identifier comparison for a given frame format
  function automatic logic [ID_W-1:0] fmt_mask(input logic [ID_W-1:0] m,
                                               input logic ext);
    logic [ID_W-1:0] keep;
    keep = ext ? {ID_W{1'b1}} : {{STD_W{1'b1}}, {EXT_LO{1'b0}}};
    return m & keep;
  endfunction

  // One entry's verdict on one frame
  function automatic logic entry_match(input filt_word_t pat,
                                       input filt_word_t msk,
                                       input logic en,
                                       input logic f_ide,
                                       input logic [ID_W-1:0] f_id);
    logic id_ok, ide_ok;
    id_ok  = ((f_id ^ pat.id) & fmt_mask(msk.id, f_ide)) == '0;
    ide_ok = !msk.ide || (f_ide == pat.ide);
    return en && id_ok && ide_ok;
  endfunction
endpackage

// File: rtl/filt_entry.sv
module filt_entry
  import can_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pat,
  input  logic              wr_msk,
  input  logic [WORD_W-1:0] wdata,
  input  logic              frm_ide,
  input  logic [ID_W-1:0]   frm_id,
  output logic              hit,
  output logic              en
);
  filt_word_t pat_q, msk_q;
  logic       en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      msk_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_pat) pat_q <= filt_word_t'(wdata[WORD_W-2:0]);
      if (wr_msk) msk_q <= filt_word_t'(wdata[WORD_W-2:0]);
      if (wr_pat || wr_msk) en_q <= wdata[WORD_W-1];
    end
  end

  assign hit = entry_match(pat_q, msk_q, en_q, frm_ide, frm_id);
  assign en  = en_q;
endmodule

// File: rtl/store_stage.sv
module store_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic hit,
  input  logic full,
  output logic store
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store <= 1'b0;
    else        store <= valid && hit && !full;
  end
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_FILT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              frm_valid,
  input  logic              frm_ide,
  input  logic [ID_W-1:0]   frm_id,
  input  logic              fifo_full,
  output logic              store_o
);
  localparam int NV = (NUM_FILT == 0) ? 1 : NUM_FILT;

  logic          acc_hit;   // combined accept decision for the current frame
  logic [NV-1:0] en_vec;    // enable state of each entry

  generate
    if (NUM_FILT == 0) begin : g_pass
      assign acc_hit = 1'b1;
      assign en_vec  = '0;
    end else begin : g_filt
      logic [NUM_FILT-1:0] hit_vec;
      for (genvar i = 0; i < NUM_FILT; i++) begin : g_ent
        logic sel;
        assign sel = cfg_we && (cfg_addr[1] == 1'(i));
        filt_entry i_ent (
          .clk     (clk),
          .rst_n   (rst_n),
          .wr_pat  (sel && !cfg_addr[0]),
          .wr_msk  (sel &&  cfg_addr[0]),
          .wdata   (cfg_wdata),
          .frm_ide (frm_ide),
          .frm_id  (frm_id),
          .hit     (hit_vec[i]),
          .en      (en_vec[i])
        );
      end
      assign acc_hit = |hit_vec;
    end
  endgenerate

  store_stage i_store (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (frm_valid),
    .hit   (acc_hit),
    .full  (fifo_full),
    .store (store_o)
  );
endmodule

// File: rtl/rx_accept_filter_chk.sv
module rx_accept_filter_chk #(
  parameter int NUM_FILT = 2,
  parameter int NV = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_valid,
  input logic          fifo_full,
  input logic          store_o,
  input logic          acc_hit,
  input logic [NV-1:0] en_vec
);
  // R6
  store_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> $past(frm_valid));
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_o && !frm_valid |=> !store_o);
  // R7
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> !$past(fifo_full));
  // R2
  hit_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && acc_hit && !fifo_full |=> store_o);
  // R2
  miss_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !acc_hit |=> !store_o);
  // R5
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_FILT > 0) && (en_vec == '0) |-> !acc_hit);
  // R8
  nofilt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_FILT == 0) && frm_valid && !fifo_full |=> store_o);
endmodule

bind rx_accept_filter rx_accept_filter_chk #(.NUM_FILT(NUM_FILT), .NV(NV)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .fifo_full (fifo_full),
  .store_o   (store_o),
  .acc_hit   (acc_hit),
  .en_vec    (en_vec)
);

// File: tb/test_rx_accept_filter.sv
module test_rx_accept_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [30:0] cfg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic        frm_ide = 1'b0;
  logic [28:0] frm_id = '0;
  logic        fifo_full = 1'b0;
  logic        store_a, store_z;

  int errors = 0;
  int checks = 0;

  // bench-side copy of what software has programmed
  bit        m_en   [2];
  bit        m_pide [2];
  bit [28:0] m_pid  [2];
  bit        m_mide [2];
  bit [28:0] m_mid  [2];

  always #2.5 clk = ~clk;

  rx_accept_filter #(.NUM_FILT(2)) i_rx_accept_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_ide(frm_ide),
    .frm_id(frm_id), .fifo_full(fifo_full), .store_o(store_a));

  rx_accept_filter #(.NUM_FILT(0)) i_rx_accept_filter_none (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_ide(frm_ide),
    .frm_id(frm_id), .fifo_full(fifo_full), .store_o(store_z));

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // acceptance per requirement text, evaluated bit by bit
  function automatic bit expect_accept(input bit ide, input bit [28:0] id);
    for (int f = 0; f < 2; f++) begin
      bit ok = m_en[f];
      for (int b = 0; b < 29; b++)
        if (m_mid[f][b] && (ide || b >= 18) && (id[b] != m_pid[f][b])) ok = 0;
      if (m_mide[f] && (ide != m_pide[f])) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  task automatic wr(input int f, input bit is_mask, input bit en,
                    input bit ide, input bit [28:0] bits);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = {f[0], is_mask};
    cfg_wdata = {en, ide, bits};
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[f] = en;
    if (is_mask) begin m_mide[f] = ide; m_mid[f] = bits; end
    else         begin m_pide[f] = ide; m_pid[f] = bits; end
  endtask

  task automatic frame(input bit ide, input bit [28:0] id, input bit full,
                       input string tag);
    bit ea, ez;
    ea = expect_accept(ide, id) && !full;
    ez = !full;
    @(negedge clk);
    frm_valid = 1'b1; frm_ide = ide; frm_id = id; fifo_full = full;
    @(posedge clk); #1;
    chk(store_a, ea, tag);
    chk(store_z, ez, {tag, "/R8"});
    @(negedge clk);
    frm_valid = 1'b0; fifo_full = 1'b0;
    @(posedge clk); #1;
    chk(store_a, 1'b0, "R6 pulse");
    chk(store_z, 1'b0, "R6 pulse");
  endtask

  task automatic t_reset;
    #1;
    chk(store_a, 1'b0, "R1 reset");
    chk(store_z, 1'b0, "R1 reset");
    frame(1'b1, 29'h0, 1'b0, "R1 disabled");
    frame(1'b0, 29'h1555_5555, 1'b0, "R1 disabled");
  endtask

  task automatic t_exact;
    wr(0, 0, 1, 1, 29'h1ABC_DEF0);
    wr(0, 1, 1, 1, 29'h1FFF_FFFF);
    frame(1'b1, 29'h1ABC_DEF0, 1'b0, "R2 exact");
    frame(1'b1, 29'h1ABC_DEF1, 1'b0, "R2 lsb diff");
    frame(1'b1, 29'h0ABC_DEF0, 1'b0, "R2 msb diff");
  endtask

  task automatic t_dontcare;
    wr(0, 1, 1, 1, 29'h1FFF_FF00);
    frame(1'b1, 29'h1ABC_DE5A, 1'b0, "R2 dont care");
    frame(1'b1, 29'h1ABC_DFFF, 1'b0, "R2 masked miss");
  endtask

  task automatic t_ide;
    wr(1, 0, 1, 0, {11'h123, 18'h0});
    wr(1, 1, 1, 1, {11'h7FF, 18'h0});
    frame(1'b0, {11'h123, 18'h0}, 1'b0, "R3 std match");
    frame(1'b1, {11'h123, 18'h0}, 1'b0, "R3 ext rejected");
    wr(1, 1, 1, 0, {11'h7FF, 18'h0});
    frame(1'b1, {11'h123, 18'h0}, 1'b0, "R3 ide dont care");
  endtask

  task automatic t_std;
    wr(1, 1, 1, 1, 29'h1FFF_FFFF);
    frame(1'b0, {11'h123, 18'h2_A5C3}, 1'b0, "R4 std low bits");
    frame(1'b0, {11'h124, 18'h0}, 1'b0, "R4 std miss");
    frame(1'b1, {11'h123, 18'h2_A5C3}, 1'b0, "R4 ext low bits");
  endtask

  task automatic t_enable;
    wr(0, 1, 0, 1, 29'h1FFF_FFFF);
    frame(1'b1, 29'h1ABC_DEF0, 1'b0, "R5 entry off");
    frame(1'b0, {11'h123, 18'h0}, 1'b0, "R5 other on");
    wr(1, 0, 0, 0, {11'h123, 18'h0});
    frame(1'b0, {11'h123, 18'h0}, 1'b0, "R5 all off");
    wr(0, 0, 1, 1, 29'h1ABC_DEF0);
    frame(1'b1, 29'h1ABC_DEF0, 1'b0, "R9 re-enable");
  endtask

  task automatic t_full;
    frame(1'b1, 29'h1ABC_DEF0, 1'b1, "R7 full");
    frame(1'b1, 29'h1ABC_DEF0, 1'b0, "R7 after full");
  endtask

  task automatic t_idle;
    @(negedge clk);
    frm_valid = 1'b0; frm_ide = 1'b1; frm_id = 29'h1ABC_DEF0;
    repeat (3) @(posedge clk);
    #1;
    chk(store_a, 1'b0, "R6 no strobe");
    chk(store_z, 1'b0, "R6 no strobe");
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int f = 0; f < 2; f++) begin
      m_en[f] = 0; m_pide[f] = 0; m_pid[f] = '0; m_mide[f] = 0; m_mid[f] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_exact;
    t_dontcare;
    t_ide;
    t_std;
    t_enable;
    t_full;
    t_idle;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule